// File: doc/BRIEF.md
# Self-Scrubbing Triplicated Register with Upset Monitor

This block holds one word of state in three redundant copies. Each copy has its own domain input. When the load strobe is high, every copy takes the word on its own input. When the strobe is low, every copy is rewritten from the bitwise two-of-three vote. A copy that has flipped is therefore repaired at the next clock edge, and a state machine built on the register recovers without any outside help.

Three separate voters produce the three domain outputs, so a fault in one voter reaches only one domain. Each domain also drives a pad-block bit. The bit goes high when that domain's copy differs from the voted word, so a wired output stage can drop the faulty driver.

A monitor counts how many distinct copies disagree with the vote in a cycle:
- One copy disagreeing is the tolerated case. It raises a one-cycle flag and advances a saturating correction counter.
- Two or more copies disagreeing means the redundancy has been defeated. This sets an alarm that stays high until reset.

Top module: `tmr_refresh_reg`

## Requirements
- R1: While reset is low, all three copies hold RST_VAL (default 0), so q0, q1 and q2 read RST_VAL. After reset, pad_block, err_single, err_multi and fix_cnt are all zero.
- R2: At a clock edge with load high, copy k takes input dk. From the next cycle, every qk equals the bitwise majority of the three copies: a bit is 1 when at least two copies hold 1.
- R3: At a clock edge with load low, every copy is rewritten with the voted word. Afterwards pad_block is 0 and q0..q2 keep their previous value.
- R4: q0, q1 and q2 come from three separate voters and always carry the same value.
- R5: pad_block bit k (bit 0 for domain 0, bit 2 for domain 2) is 1 when copy k differs from the voted word in any bit, and 0 when it agrees (pad enabled).
- R6: err_single is high for exactly the cycle after a cycle in which exactly one copy disagreed with the vote, and low otherwise.
- R7: After a cycle in which two or more distinct copies disagree with the vote (even on different bits), err_multi goes high and stays high until reset, whatever is loaded later.
- R8: fix_cnt (CW = 16 bits) increments by one after each cycle with exactly one disagreeing copy. It saturates at 65535, and it does not count cycles with multiple disagreement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Write all copies from their domain inputs |
| d0 | input | W | Domain 0 write data |
| d1 | input | W | Domain 1 write data |
| d2 | input | W | Domain 2 write data |
| q0 | output | W | Domain 0 voted word |
| q1 | output | W | Domain 1 voted word |
| q2 | output | W | Domain 2 voted word |
| pad_block | output | 3 | Per-domain pad block (1 = copy disagrees) |
| err_single | output | 1 | One-cycle flag: a single copy was wrong |
| err_multi | output | 1 | Sticky alarm: several copies were wrong |
| fix_cnt | output | CW | Saturating count of single-copy corrections |

## Verification
The difficult condition to create from the ports is a disagreement between copies, because no input upsets a stored bit directly. The bench creates one by loading unequal words into the three domains. A chosen set of differing bits gives one wrong copy, and splitting the differing bits between two domains gives two wrong copies at once. The counter's saturation edge is reached by holding such a load for 65534 edges and then adding single events one at a time.

// File: rtl/tmr_refresh_reg.sv
module tmr_refresh_reg #(
  parameter int W = 8,
  parameter int CW = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  d0,
  input  logic [W-1:0]  d1,
  input  logic [W-1:0]  d2,
  output logic [W-1:0]  q0,
  output logic [W-1:0]  q1,
  output logic [W-1:0]  q2,
  output logic [2:0]    pad_block,
  output logic          err_single,
  output logic          err_multi,
  output logic [CW-1:0] fix_cnt
);
  localparam int N = 3;

  logic [W-1:0] cp   [N];
  logic [W-1:0] din  [N];
  logic [W-1:0] vote [N];
  logic [1:0]   nbad;
  logic         single_now, multi_now;

  assign din[0] = d0;
  assign din[1] = d1;
  assign din[2] = d2;

  for (genvar k = 0; k < N; k++) begin : g_dom
    assign vote[k]      = (cp[0] & cp[1]) | (cp[0] & cp[2]) | (cp[1] & cp[2]);
    assign pad_block[k] = |(cp[k] ^ vote[k]);
  end

  assign q0 = vote[0];
  assign q1 = vote[1];
  assign q2 = vote[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) cp[k] <= RST_VAL;
    end else begin
      for (int k = 0; k < N; k++) cp[k] <= load ? din[k] : vote[k];
    end
  end

  assign nbad       = {1'b0, pad_block[0]} + {1'b0, pad_block[1]} + {1'b0, pad_block[2]};
  assign single_now = (nbad == 2'd1);
  assign multi_now  = nbad[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_single <= 1'b0;
      err_multi  <= 1'b0;
      fix_cnt    <= '0;
    end else begin
      err_single <= single_now;
      err_multi  <= err_multi | multi_now;
      if (single_now && fix_cnt != '1) fix_cnt <= fix_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_refresh_reg_chk.sv
module tmr_refresh_reg_chk #(
  parameter int W = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic [W-1:0]  q0,
  input logic [W-1:0]  q1,
  input logic [W-1:0]  q2,
  input logic [2:0]    pad_block,
  input logic          err_single,
  input logic          err_multi,
  input logic [CW-1:0] fix_cnt
);
  a_r4_voters_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (q0 == q1) && (q1 == q2));

  a_r3_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (pad_block == 3'b000));

  a_r3_refresh_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q0));

  a_r6_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pad_block) == 1) |=> err_single);

  a_r6_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pad_block) != 1) |=> !err_single);

  a_r7_multi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_multi |=> err_multi);

  a_r7_multi_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pad_block) >= 2) |=> err_multi);

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(pad_block) == 1) && (fix_cnt != {CW{1'b1}})) |=>
      (fix_cnt == CW'($past(fix_cnt) + 1'b1)));

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_cnt == {CW{1'b1}}) |=> (fix_cnt == {CW{1'b1}}));
endmodule

bind tmr_refresh_reg tmr_refresh_reg_chk #(.W(W), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .q0(q0), .q1(q1), .q2(q2),
  .pad_block(pad_block), .err_single(err_single), .err_multi(err_multi),
  .fix_cnt(fix_cnt)
);

// File: tb/test_tmr_refresh_reg.sv
module test_tmr_refresh_reg;
  localparam int W = 8;
  localparam int CW = 16;
  localparam int NV = 6;
  // each entry: d0, d1, d2, expected vote, expected pad_block
  localparam logic [34:0] VEC [NV] = '{
    {8'hAA, 8'hAA, 8'hAA, 8'hAA, 3'b000},
    {8'h5A, 8'hA5, 8'hA5, 8'hA5, 3'b001},
    {8'h3C, 8'hC3, 8'h3C, 8'h3C, 3'b010},
    {8'h0F, 8'h0F, 8'hF0, 8'h0F, 3'b100},
    {8'hFF, 8'h00, 8'h00, 8'h00, 3'b001},
    {8'h12, 8'h34, 8'h34, 8'h34, 3'b001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [W-1:0] d0 = '0, d1 = '0, d2 = '0;
  logic [W-1:0] q0, q1, q2;
  logic [2:0] pad_block;
  logic err_single, err_multi;
  logic [CW-1:0] fix_cnt;

  int n_chk = 0;
  int n_bad = 0;
  int model_cnt = 0;

  always #10 clk = ~clk;

  tmr_refresh_reg #(.W(W), .CW(CW)) i_tmr_refresh_reg (
    .clk(clk), .rst_n(rst_n), .load(load), .d0(d0), .d1(d1), .d2(d2),
    .q0(q0), .q1(q1), .q2(q2), .pad_block(pad_block),
    .err_single(err_single), .err_multi(err_multi), .fix_cnt(fix_cnt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    load = 1'b0;
    step();
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step();
    step();
    rst_n = 1'b1;
    check("R1 q0 reset", 32'(q0), 32'h0);
    check("R1 pad_block reset", 32'(pad_block), 32'h0);
    check("R1 flags reset", 32'({err_single, err_multi}), 32'h0);
    check("R1 fix_cnt reset", 32'(fix_cnt), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] ev;
      logic [2:0] eb;
      ev = VEC[i][10:3];
      eb = VEC[i][2:0];
      load = 1'b1;
      d0 = VEC[i][34:27];
      d1 = VEC[i][26:19];
      d2 = VEC[i][18:11];
      step();
      load = 1'b0;
      check("R2 q0 vote", 32'(q0), 32'(ev));
      check("R4 q1 vs q0", 32'(q1), 32'(q0));
      check("R4 q2 vs q0", 32'(q2), 32'(q0));
      check("R5 pad_block", 32'(pad_block), 32'(eb));
      step();
      if ($countones(eb) == 1) model_cnt++;
      check("R3 q0 after refresh", 32'(q0), 32'(ev));
      check("R3 pad_block after refresh", 32'(pad_block), 32'h0);
      check("R6 err_single pulse", 32'(err_single), 32'($countones(eb) == 1));
      step();
      check("R6 err_single drops", 32'(err_single), 32'h0);
      check("R8 fix_cnt", 32'(fix_cnt), 32'(model_cnt));
      check("R7 no alarm", 32'(err_multi), 32'h0);
    end

    // two copies wrong on different bits
    load = 1'b1;
    d0 = 8'h01; d1 = 8'h02; d2 = 8'h00;
    step();
    load = 1'b0;
    check("R5 two blocked", 32'(pad_block), 32'h3);
    check("R2 multi vote", 32'(q0), 32'h0);
    step();
    check("R7 alarm set", 32'(err_multi), 32'h1);
    check("R6 no single on multi", 32'(err_single), 32'h0);
    check("R8 no count on multi", 32'(fix_cnt), 32'(model_cnt));
    load = 1'b1;
    d0 = 8'h77; d1 = 8'h77; d2 = 8'h77;
    step();
    load = 1'b0;
    step();
    step();
    check("R7 alarm sticky", 32'(err_multi), 32'h1);
    check("R2 clean load", 32'(q2), 32'h77);
    do_reset();
    check("R7 alarm cleared by reset", 32'(err_multi), 32'h0);
    check("R1 q1 after reset", 32'(q1), 32'h0);

    // saturation of correction counter
    load = 1'b1;
    d0 = 8'hFF; d1 = 8'h00; d2 = 8'h00;
    repeat (65534) @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    step();
    check("R8 count before limit", 32'(fix_cnt), 32'hFFFE);
    for (int j = 0; j < 2; j++) begin
      load = 1'b1;
      step();
      load = 1'b0;
      step();
    end
    check("R8 count saturated", 32'(fix_cnt), 32'hFFFF);
    check("R7 no alarm on singles", 32'(err_multi), 32'h0);
    check("R3 recovered value", 32'(q0), 32'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule